// File: doc/BRIEF.md
# Serial Peripheral Port with Multimaster Fault Detection

This block is a synchronous serial port that can act either as the clock-generating master or as a selected slave on a four-wire serial bus. As master, it produces a gated serial clock whose half period comes from a programmable divisor. It shifts a transmit word out on its master-out line and captures the reply from the master-in line. As slave, it follows an external serial clock while its active-low select input is low. In that role it takes data from the master-out line and answers on the master-in line.

Clock polarity, clock phase, the role, the word length (8, 16 or 32 bits) and an open-drain option for the slave's answer line are configuration inputs. Software sees a parallel transmit word, a start strobe, the received word held in a register, a one-cycle done pulse and a sticky mode-fault flag. Every pad is split into separate value and enable signals, so the tri-state buffers sit outside the block.

When the select input is pulled low while the port is set up as master, another device is trying to be master. The port then aborts any transfer, releases its clock and data outputs, and raises the fault flag. The flag stays set until it is cleared.

Top module: `spi_port`

## Requirements
- R1: The master serial clock `sck_o` rests at the level of `cfg_cpol` when no word is moving. It makes exactly one full cycle per bit, which is two transitions per bit. It is back at `cfg_cpol` when the word ends.
- R2: The leading edge is the clock edge that leaves the idle level. With `cfg_cpha`=0, data is sampled on the leading edge and launched on the trailing edge, and the first bit is already on the line before the first edge. With `cfg_cpha`=1, data is launched on the leading edge and sampled on the trailing edge. Bits move most significant first.
- R3: Each master clock half period lasts max(`cfg_div`,2)+1 cycles of `clk`.
- R4: `cfg_len` sets the word length: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. The transmitted bits are the low bits of `tx_word`. `rx_word` is right-aligned, with its upper bits zero.
- R5: As master without a fault, `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. The reply is taken from `miso_i`.
- R6: As slave (`cfg_master`=0), `sck_oe` and `mosi_oe` are 0 and data is received from `mosi_i`. `miso_oe` can be 1 only while `ss_n` is low, and `miso_oe` is 0 whenever `ss_n` is high.
- R7: With `cfg_odrain`=1 the slave never drives `miso_o` high. `miso_o` is 0, and `miso_oe` is 1 only while the outgoing bit is 0.
- R8: As slave with `ss_n` high, activity on `sck_i` and `mosi_i` produces no done pulse. It also leaves `rx_word` unchanged and does not advance the bit count of a later selected word.
- R9: If `ss_n` goes low while `cfg_master`=1, `mode_fault` rises within 4 clock cycles. Any running word is dropped: `busy` falls, no done pulse follows, and `sck_oe` and `mosi_oe` go to 0.
- R10: `mode_fault` stays set until `fault_clr` is pulsed. A clear is overridden while `ss_n` is still low in master role.
- R11: `done` is a one-cycle pulse after the last bit of a word. `rx_word` then holds that word until the next done.
- R12: After reset `done`, `busy`, `mode_fault` and `rx_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 samples on the trailing edge |
| cfg_master | input | 1 | 1 selects the master role, 0 selects the slave role |
| cfg_odrain | input | 1 | Open-drain drive for the slave answer line |
| cfg_len | input | 2 | Word length code: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 32 bits |
| cfg_div | input | DIV_W | Baud divisor for the master clock half period |
| tx_word | input | WORD_W | Word to transmit, right-aligned |
| start | input | 1 | Starts a master word when idle |
| fault_clr | input | 1 | Clears the sticky mode fault |
| rx_word | output | WORD_W | Last received word, right-aligned |
| done | output | 1 | One-cycle pulse at the end of a word |
| busy | output | 1 | Master word in progress |
| mode_fault | output | 1 | Sticky multimaster fault flag |
| sck_i | input | 1 | Serial clock from the bus (slave role) |
| sck_o | output | 1 | Serial clock driven by the master |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| mosi_i | input | 1 | Master-out line value as seen from the bus |
| mosi_o | output | 1 | Master-out data driven in master role |
| mosi_oe | output | 1 | Output enable for the master-out pad |
| miso_i | input | 1 | Master-in line value as seen from the bus |
| miso_o | output | 1 | Master-in data driven in slave role |
| miso_oe | output | 1 | Output enable for the master-in pad |
| ss_n | input | 1 | Active-low select input; a fault detector in master role |

## Verification
The hardest situation to reach is a select collision in the middle of a master word. The serial clock must be between edges at that moment, and the bench has to show that the word is dropped and not finished. The stimulus starts a 32-bit master word with a slow divisor and pulls `ss_n` low after a fixed number of cycles. It then watches for a done pulse over a window longer than the remaining word. Next it checks that the flag survives both `ss_n` returning high and a clear issued while `ss_n` is still low. Random master and slave words over every polarity, phase, length and divisor combination run against a bench-side bus model, with directed cases for the clamped divisor and the open-drain answer line.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  // word length code -> number of bits, clipped to the datapath width
  function automatic int word_bits(input logic [1:0] code, input int maxw);
    int n;
    case (code)
      2'd0:    n = 8;
      2'd1:    n = 16;
      default: n = 32;
    endcase
    return (n > maxw) ? maxw : n;
  endfunction

  // clock cycles in one serial-clock half period
  function automatic int half_cycles(input int div);
    return ((div < 2) ? 2 : div) + 1;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  ld_word,
  input  logic [CW-1:0] nbits,
  input  logic          cpha,
  input  logic          lead,
  input  logic          trail,
  input  logic          sdi,
  output logic          sdo,
  output logic          word_end,
  output logic [W-1:0]  rx_next
);
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          smp;
  logic          bit_in;
  logic [W-1:0]  mask;

  always_comb begin
    for (int i = 0; i < W; i++) mask[i] = (i < int'(nbits));
  end

  assign bit_in   = cpha ? sdi : smp;
  assign word_end = trail && (cnt == nbits - CW'(1));
  assign rx_next  = {sh[W-2:0], bit_in} & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      smp <= 1'b0;
      sdo <= 1'b0;
    end else if (load) begin
      sh  <= ld_word << (W - int'(nbits));
      sdo <= ld_word[nbits - CW'(1)];
      cnt <= '0;
    end else begin
      if (lead) begin
        if (cpha) sdo <= sh[W-1];
        else      smp <= sdi;
      end
      if (trail) begin
        sh  <= {sh[W-2:0], bit_in};
        if (!cpha) sdo <= sh[W-2];
        cnt <= word_end ? '0 : cnt + CW'(1);
      end
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail)); // R2
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_master,
  input  logic              cfg_odrain,
  input  logic [1:0]        cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              start,
  input  logic              fault_clr,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              busy,
  output logic              mode_fault,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n
);
  localparam int CW = $clog2(WORD_W) + 1;

  // synchronised bus inputs
  logic [3:0] raw_in, syn;
  logic sck_s, mosi_s, miso_s, ss_s;
  assign raw_in = {ss_n, miso_i, mosi_i, sck_i};
  assign {ss_s, miso_s, mosi_s, sck_s} = syn;

  spi_sync #(.W(4), .RST(4'hF)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  // named internal events
  logic [CW-1:0] nbits;
  logic m_act, fault_set, start_ok, tick;
  logic m_lead, m_trail, s_en, s_edge, s_lead, s_trail, s_load;
  logic sh_load, sh_lead, sh_trail, sh_sdi, sdo, word_end;
  logic [WORD_W-1:0] rx_next;
  logic sck_q, sck_d, ss_d;

  assign nbits     = CW'(word_bits(cfg_len, WORD_W));
  assign m_act     = cfg_master && !mode_fault;
  assign fault_set = cfg_master && !ss_s;
  assign start_ok  = start && m_act && !busy && !fault_set;

  spi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div), .tick(tick)
  );

  assign m_lead  = busy && tick && (sck_q == cfg_cpol);
  assign m_trail = busy && tick && (sck_q != cfg_cpol);

  assign s_en    = !cfg_master && !ss_s;
  assign s_edge  = sck_s ^ sck_d;
  assign s_lead  = s_en && s_edge && (sck_s != cfg_cpol);
  assign s_trail = s_en && s_edge && (sck_s == cfg_cpol);
  assign s_load  = s_en && ss_d;

  assign sh_load  = start_ok || s_load || (s_en && word_end);
  assign sh_lead  = m_lead || s_lead;
  assign sh_trail = m_trail || s_trail;
  assign sh_sdi   = cfg_master ? miso_s : mosi_s;

  spi_shifter #(.W(WORD_W), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_word(tx_word),
    .nbits(nbits), .cpha(cfg_cpha), .lead(sh_lead), .trail(sh_trail),
    .sdi(sh_sdi), .sdo(sdo), .word_end(word_end), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      sck_q      <= 1'b0;
      sck_d      <= 1'b1;
      ss_d       <= 1'b1;
      mode_fault <= 1'b0;
      done       <= 1'b0;
      rx_word    <= '0;
    end else begin
      sck_d <= sck_s;
      ss_d  <= ss_s;
      done  <= word_end;
      if (word_end) rx_word <= rx_next;

      if (fault_set)      mode_fault <= 1'b1;
      else if (fault_clr) mode_fault <= 1'b0;

      if (fault_set || (m_trail && word_end)) begin
        busy  <= 1'b0;
        sck_q <= cfg_cpol;
      end else if (start_ok) begin
        busy  <= 1'b1;
        sck_q <= cfg_cpol;
      end else if (!busy) begin
        sck_q <= cfg_cpol;
      end else if (tick) begin
        sck_q <= ~sck_q;
      end
    end
  end

  // pad drive
  logic s_drive;
  assign s_drive = !cfg_master && !ss_n;
  assign sck_o   = sck_q;
  assign sck_oe  = m_act;
  assign mosi_o  = sdo;
  assign mosi_oe = m_act;
  assign miso_o  = cfg_odrain ? 1'b0 : sdo;
  assign miso_oe = s_drive && (!cfg_odrain || !sdo);

  AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sck_o == cfg_cpol)); // R1
  AST_BUSY_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mode_fault); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !fault_clr) |=> mode_fault); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master || ss_n) |-> !miso_oe); // R6
  AST_OD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_odrain && miso_oe) |-> !miso_o); // R7
endmodule

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_master = 0, cfg_odrain = 0;
  logic [1:0] cfg_len = 0;
  logic [7:0] cfg_div = 8'd2;
  logic [31:0] tx_word = 0;
  logic start = 0, fault_clr = 0;
  logic [31:0] rx_word;
  logic done, busy, mode_fault;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n = 1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_master(cfg_master), .cfg_odrain(cfg_odrain), .cfg_len(cfg_len),
    .cfg_div(cfg_div), .tx_word(tx_word), .start(start), .fault_clr(fault_clr),
    .rx_word(rx_word), .done(done), .busy(busy), .mode_fault(mode_fault),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .ss_n(ss_n)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  function automatic int nb(input logic [1:0] c);
    return (c == 0) ? 8 : (c == 1) ? 16 : 32;
  endfunction
  function automatic logic [31:0] msk(input int n);
    logic [63:0] m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction
  function automatic int half(input int d);
    return (d < 2 ? 2 : d) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // master word with a bench-side slave on miso_i
  task automatic master_word(input logic pol, input logic pha, input logic [1:0] lc,
                             input int dv, input logic [31:0] tw, input logic [31:0] sw);
    int n = nb(lc), edges = 0, leads = 0, trails = 0, last_cyc = 0, per_err = 0;
    int d0 = done_cnt;
    logic [31:0] cap = 0;
    logic prev;
    bit seen = 0;
    @(negedge clk);
    cfg_master = 1; cfg_cpol = pol; cfg_cpha = pha; cfg_len = lc; cfg_div = 8'(dv);
    tx_word = tw; miso_i = sw[n-1];
    repeat (3) @(negedge clk);
    chk(sck_o == pol, "R1 idle level", {31'd0, sck_o}, {31'd0, pol});
    chk(sck_oe && mosi_oe && !miso_oe, "R5 master enables", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd6);
    prev = sck_o;
    start = 1; @(negedge clk); start = 0;
    for (int t = 0; t < 4000 && !seen; t++) begin
      if (sck_o != prev) begin
        if (edges > 0 && (cyc - last_cyc) != half(dv)) per_err++;
        last_cyc = cyc; edges++;
        if (sck_o != pol) begin
          leads++;
          if (!pha) cap = {cap[30:0], mosi_o};
          else miso_i = sw[n-leads];
        end else begin
          trails++;
          if (pha) cap = {cap[30:0], mosi_o};
          else if (trails < n) miso_i = sw[n-1-trails];
        end
        prev = sck_o;
      end
      if (done) seen = 1;
      @(negedge clk);
    end
    chk(edges == 2*n, "R1 edge count", edges, 2*n);
    chk(per_err == 0, "R3 half period", per_err, 0);
    chk(cap == (tw & msk(n)), "R2 R4 mosi bits", cap, tw & msk(n));
    chk(rx_word == (sw & msk(n)), "R4 R5 rx word", rx_word, sw & msk(n));
    chk(done_cnt == d0 + 1, "R11 one done", done_cnt, d0 + 1);
    chk(sck_o == pol && !busy, "R1 back idle", {30'd0, busy, sck_o}, {31'd0, pol});
  endtask

  // slave word driven by a bench-side master
  task automatic slave_word(input logic pol, input logic pha, input logic [1:0] lc,
                            input logic od, input logic [31:0] tw, input logic [31:0] mw);
    int n = nb(lc), d0;
    logic [31:0] cap = 0, hold;
    int od_bad = 0;
    @(negedge clk);
    cfg_master = 0; cfg_cpol = pol; cfg_cpha = pha; cfg_len = lc; cfg_odrain = od;
    tx_word = tw; sck_i = pol;
    repeat (4) @(negedge clk);
    hold = rx_word; d0 = done_cnt;
    chk(!miso_oe, "R6 released while deselected", {31'd0, miso_oe}, 0);
    ss_n = 0; mosi_i = mw[n-1];
    repeat (6) @(negedge clk);
    chk(!sck_oe && !mosi_oe, "R6 slave enables", {30'd0, sck_oe, mosi_oe}, 0);
    for (int i = 0; i < n; i++) begin
      if (od && miso_oe && miso_o) od_bad++;
      if (!pha) cap = {cap[30:0], miso_oe ? miso_o : 1'b1};
      else mosi_i = mw[n-1-i];
      sck_i = ~pol;
      repeat (8) @(negedge clk);
      if (od && miso_oe && miso_o) od_bad++;
      if (pha) cap = {cap[30:0], miso_oe ? miso_o : 1'b1};
      sck_i = pol;
      if (!pha && i + 1 < n) mosi_i = mw[n-2-i];
      if (i == n - 1)
        chk(rx_word == hold, "R11 rx held until done", rx_word, hold);
      repeat (8) @(negedge clk);
    end
    chk(cap == (tw & msk(n)), "R2 R6 miso bits", cap, tw & msk(n));
    chk(rx_word == (mw & msk(n)), "R4 R6 slave rx", rx_word, mw & msk(n));
    chk(done_cnt == d0 + 1, "R11 slave done", done_cnt, d0 + 1);
    if (od) chk(od_bad == 0, "R7 open drain never high", od_bad, 0);
    ss_n = 1;
    #1;
    chk(!miso_oe, "R6 release on deselect", {31'd0, miso_oe}, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int d0;
    logic [31:0] hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !busy && !mode_fault && rx_word == 0, "R12 reset state",
        {rx_word[28:0], done, busy, mode_fault}, 0);

    // directed: clamped divisor, every length
    master_word(0, 0, 2'd0, 0, 32'h0000_00A5, 32'h0000_003C);
    master_word(1, 1, 2'd1, 1, 32'h0000_8001, 32'h0000_7FFE);
    master_word(0, 1, 2'd3, 4, 32'hDEAD_BEEF, 32'h1234_5678);
    for (int k = 0; k < 12; k++)
      master_word($urandom % 2, $urandom % 2, 2'($urandom % 4), 2 + $urandom % 4, $urandom, $urandom);

    // slave words, including open-drain
    cfg_master = 0; repeat (4) @(negedge clk);
    slave_word(0, 0, 2'd0, 1, 32'h0000_005A, 32'h0000_00C3);
    slave_word(1, 1, 2'd2, 0, 32'h8000_0001, 32'hF0F0_0F0F);
    for (int k = 0; k < 8; k++)
      slave_word($urandom % 2, $urandom % 2, 2'($urandom % 3), $urandom % 2, $urandom, $urandom);

    // R8: bus activity while deselected
    @(negedge clk);
    hold = rx_word; d0 = done_cnt; cfg_cpha = 0; cfg_cpol = 0;
    for (int i = 0; i < 40; i++) begin
      sck_i = ~sck_i; mosi_i = $urandom % 2;
      repeat (4) @(negedge clk);
    end
    sck_i = 0;
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 && rx_word == hold && !miso_oe, "R8 deselected ignored", rx_word, hold);
    slave_word(0, 0, 2'd0, 0, 32'h0000_0011, 32'h0000_0096);

    // R9/R10: collision in the middle of a master word
    cfg_master = 1; cfg_len = 2'd2; cfg_div = 8'd5; cfg_cpol = 0; cfg_cpha = 0;
    repeat (4) @(negedge clk);
    d0 = done_cnt;
    start = 1; @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chk(busy, "R9 word running before collision", {31'd0, busy}, 1);
    ss_n = 0;
    repeat (4) @(negedge clk);
    chk(mode_fault && !busy, "R9 fault raised and word dropped", {30'd0, mode_fault, busy}, 2);
    chk(!sck_oe && !mosi_oe, "R9 outputs released", {30'd0, sck_oe, mosi_oe}, 0);
    repeat (400) @(negedge clk);
    chk(done_cnt == d0, "R9 no done after abort", done_cnt, d0);
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    repeat (2) @(negedge clk);
    chk(mode_fault, "R10 clear overridden while selected", {31'd0, mode_fault}, 1);
    ss_n = 1;
    repeat (5) @(negedge clk);
    chk(mode_fault, "R10 sticky after select released", {31'd0, mode_fault}, 1);
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    chk(!mode_fault && sck_oe, "R10 cleared", {30'd0, mode_fault, sck_oe}, 1);
    master_word(1, 0, 2'd1, 3, 32'h0000_C0DE, 32'h0000_F00D);

    summary();
  end
endmodule